// File: doc/BRIEF.md
# TLB Invalidate and Sync Controller

This block owns the valid bits of a split translation buffer pair: one buffer for instruction fetches and one for data accesses. Each buffer is two-way set associative with 32 sets, and each entry keeps only a valid flag. Page walks, lookups, replacement and entry contents belong to other blocks. A refill port marks single entries valid. An invalidate-entry command carries an effective address, takes the set index from it, and clears that whole set in both buffers in one step. A per-entry clear strobe goes out for each buffer, so that the blocks holding the entry payloads can follow along. The block makes no bus broadcast, and invalidate requests that other bus masters place on the snoop input are ignored.

The invalidate-all opcode has no hardware support. It raises a one-cycle illegal-instruction exception pulse instead. Software clears everything by issuing 32 invalidate-entry commands and stepping the index field by one each time.

A synchronize command stalls the pipeline for as long as an external sync-hold pin stays asserted. This lets outside logic lock the translation tables while they are being updated. The pin is asynchronous and passes through two flops before use. A synchronize command that finds the pin negated retires at once and does nothing.

Top module: `tlbsync_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every valid bit in both buffers is 0, and `stall_o`, `illegal_o`, `itlb_clr_o` and `dtlb_clr_o` are 0. A reset during a stall drops the stall at once.
- R2: An accepted invalidate-entry command clears both ways of the indexed set in both buffers at the next clock edge. In the following cycle, `itlb_clr_o` and `dtlb_clr_o` each show a one-cycle pulse on exactly those two entries. Entry number = set*2 + way. Other sets are untouched, and the clear outputs are 0 in every cycle that follows no accepted invalidate.
- R3: The set index is `inv_ea_i[16:12]`, which is effective-address bits 15 to 19 when bit 0 is the most significant bit. Every other address bit has no effect. Issuing 32 invalidates that step the index from 0 to 31 leaves every entry invalid.
- R4: An accepted invalidate-all command produces `illegal_o` = 1 for exactly the following cycle and changes no valid bit.
- R5: `snoop_inv_i` and `snoop_ea_i` have no effect on any valid bit or on any output.
- R6: A synchronize command accepted while the synchronized hold is 1 sets `stall_o` from the next cycle on. `stall_o` stays 1 while the hold stays 1.
- R7: After `sync_hold_i` falls, `stall_o` stays 1 for two more cycles. It is 0 after the third clock edge: two for the synchronizer, then one for release.
- R8: A synchronize command accepted while the synchronized hold is 0 leaves `stall_o` at 0 and has no other effect.
- R9: While `stall_o` is 1, invalidate-entry, invalidate-all and synchronize commands are not accepted. They produce no clear pulse, no valid change and no exception.
- R10: A refill with `fill_req_i` = 1 sets the valid bit of entry {`fill_set_i`, `fill_way_i`} at the next edge. `fill_dside_i` = 1 selects the data buffer and 0 selects the instruction buffer. An invalidate of the same set in the same cycle wins over the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inv_req_i | input | 1 | Invalidate-entry command, one cycle |
| inv_ea_i | input | 32 | Effective address of the invalidate |
| inva_req_i | input | 1 | Invalidate-all opcode, one cycle |
| sync_req_i | input | 1 | Synchronize command, one cycle |
| sync_hold_i | input | 1 | Asynchronous external hold for synchronize |
| snoop_inv_i | input | 1 | Invalidate request from another master (ignored) |
| snoop_ea_i | input | 32 | Address of that request (ignored) |
| fill_req_i | input | 1 | Refill marks one entry valid |
| fill_dside_i | input | 1 | 1 = data buffer, 0 = instruction buffer |
| fill_set_i | input | 5 | Refill set |
| fill_way_i | input | 1 | Refill way |
| itlb_vld_o | output | 64 | Instruction buffer valid bits, entry set*2+way |
| dtlb_vld_o | output | 64 | Data buffer valid bits, entry set*2+way |
| itlb_clr_o | output | 64 | Instruction buffer per-entry clear pulse |
| dtlb_clr_o | output | 64 | Data buffer per-entry clear pulse |
| stall_o | output | 1 | Pipeline stall for synchronize |
| illegal_o | output | 1 | Illegal-instruction exception pulse |

## Verification
The invalidate path is tried in three ways.
- A full sweep of all 32 indices over fully populated buffers. Random noise in the address bits outside the index shows that the set is decoded only from bits 16:12.
- A random mix of refills, invalidates, snoops, invalidate-all and quiet synchronizes. This separates correct set clearing from clearing of neighbouring sets or of the wrong buffer.
- Same-set refill/invalidate collisions, which pin down the priority between the two.

The stall path is driven by directed hold sequences. These separate the hold latency through the synchronizer from the one-cycle release, and show that commands issued during a stall are dropped and that a reset ends the stall.

// File: rtl/tlbsync_pkg.sv
package tlbsync_pkg;

  typedef enum logic [0:0] {
    SY_IDLE = 1'b0,
    SY_WAIT = 1'b1
  } sync_st_e;

endpackage

// File: rtl/tlbsync_sync2.sv
// Two-stage synchronizer with asynchronous active-low clear.
module tlbsync_sync2 (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/tlbsync_vld_array.sv
// Valid-bit array of one translation buffer plus its per-entry clear strobe.
module tlbsync_vld_array #(
  parameter int unsigned SET_W = 5,
  parameter int unsigned WAY_W = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             inv_en_i,
  input  logic [SET_W-1:0]                 inv_set_i,
  input  logic                             fill_en_i,
  input  logic [SET_W-1:0]                 fill_set_i,
  input  logic [WAY_W-1:0]                 fill_way_i,
  output logic [(1<<(SET_W+WAY_W))-1:0]    vld_o,
  output logic [(1<<(SET_W+WAY_W))-1:0]    clr_o
);
  localparam int unsigned IDX_W   = SET_W + WAY_W;
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned WAYS    = 1 << WAY_W;

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ENTRIES-1:0] clr_q, clr_d;
  logic               vld_en;
  logic [IDX_W-1:0]   fill_idx;

  assign fill_idx = {fill_set_i, fill_way_i};
  assign vld_en   = inv_en_i | fill_en_i;

  // Next state: refill first, invalidate after, so a same-set invalidate wins.
  always_comb begin
    logic [IDX_W-1:0] ent;
    vld_d = vld_q;
    clr_d = '0;
    for (int unsigned e = 0; e < ENTRIES; e++) begin
      ent = IDX_W'(e);
      if (fill_en_i && (ent == fill_idx)) begin
        vld_d[e] = 1'b1;
      end
      if (inv_en_i && (ent[IDX_W-1 -: SET_W] == inv_set_i)) begin
        vld_d[e] = 1'b0;
        clr_d[e] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      clr_q <= '0;
    end else begin
      if (vld_en) begin
        vld_q <= vld_d;
      end
      clr_q <= clr_d;
    end
  end

  assign vld_o = vld_q;
  assign clr_o = clr_q;

  AST_CLR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en_i |=> ($countones(clr_o) == WAYS)); // R2
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_en_i |=> (clr_o == '0)); // R2
  AST_CLR_LEAVES_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_o & vld_o) == '0)); // R2
  AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !(inv_en_i && (inv_set_i == fill_set_i))) |=> vld_o[$past(fill_idx)]); // R10
  AST_FILL_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && inv_en_i && (inv_set_i == fill_set_i)) |=> !vld_o[$past(fill_idx)]); // R10
endmodule

// File: rtl/tlbsync_seq.sv
// Command acceptance, synchronize stall sequencing and invalidate-all trap.
module tlbsync_seq
  import tlbsync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inv_req_i,
  input  logic inva_req_i,
  input  logic sync_req_i,
  input  logic hold_s_i,
  output logic inv_go_o,
  output logic stall_o,
  output logic illegal_o
);
  sync_st_e st_q, st_d;
  logic     st_en;
  logic     ill_q, ill_d;
  logic     accept;

  assign accept = (st_q == SY_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SY_IDLE: if (sync_req_i && hold_s_i) st_d = SY_WAIT;
      SY_WAIT: if (!hold_s_i)              st_d = SY_IDLE;
      default:                             st_d = SY_IDLE;
    endcase
  end

  assign st_en    = (st_d != st_q);
  assign ill_d    = inva_req_i & accept;
  assign inv_go_o = inv_req_i & accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SY_IDLE;
      ill_q <= 1'b0;
    end else begin
      if (st_en) begin
        st_q <= st_d;
      end
      ill_q <= ill_d;
    end
  end

  assign stall_o   = (st_q == SY_WAIT);
  assign illegal_o = ill_q;

  AST_STALL_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && sync_req_i && hold_s_i) |=> stall_o); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && hold_s_i) |=> stall_o); // R6
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !hold_s_i) |=> !stall_o); // R7
  AST_QUIET_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && !hold_s_i) |=> !stall_o); // R8
  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && inva_req_i) |=> illegal_o); // R4
  AST_NO_TRAP_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !illegal_o); // R9
endmodule

// File: rtl/tlbsync_ctrl.sv
module tlbsync_ctrl #(
  parameter int unsigned EA_W    = 32,
  parameter int unsigned SET_W   = 5,
  parameter int unsigned WAY_W   = 1,
  parameter int unsigned IDX_LSB = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inv_req_i,
  input  logic [EA_W-1:0]               inv_ea_i,
  input  logic                          inva_req_i,
  input  logic                          sync_req_i,
  input  logic                          sync_hold_i,
  input  logic                          snoop_inv_i,
  input  logic [EA_W-1:0]               snoop_ea_i,
  input  logic                          fill_req_i,
  input  logic                          fill_dside_i,
  input  logic [SET_W-1:0]              fill_set_i,
  input  logic [WAY_W-1:0]              fill_way_i,
  output logic [(1<<(SET_W+WAY_W))-1:0] itlb_vld_o,
  output logic [(1<<(SET_W+WAY_W))-1:0] dtlb_vld_o,
  output logic [(1<<(SET_W+WAY_W))-1:0] itlb_clr_o,
  output logic [(1<<(SET_W+WAY_W))-1:0] dtlb_clr_o,
  output logic                          stall_o,
  output logic                          illegal_o
);
  localparam int unsigned ENTRIES = 1 << (SET_W + WAY_W);
  localparam int unsigned NBUF    = 2;

  logic               rst_sync_n;
  logic               hold_s;
  logic               inv_go;
  logic [SET_W-1:0]   inv_set;
  logic [ENTRIES-1:0] vld_w [NBUF];
  logic [ENTRIES-1:0] clr_w [NBUF];
  logic               unused_inputs;

  // Snoop requests and address bits outside the index take no part.
  assign unused_inputs = ^{snoop_inv_i, snoop_ea_i, inv_ea_i};

  tlbsync_sync2 u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d_i    (1'b1),
    .q_o    (rst_sync_n)
  );

  tlbsync_sync2 u_hold_sync (
    .clk    (clk),
    .arst_n (rst_sync_n),
    .d_i    (sync_hold_i),
    .q_o    (hold_s)
  );

  tlbsync_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .inv_req_i  (inv_req_i),
    .inva_req_i (inva_req_i),
    .sync_req_i (sync_req_i),
    .hold_s_i   (hold_s),
    .inv_go_o   (inv_go),
    .stall_o    (stall_o),
    .illegal_o  (illegal_o)
  );

  assign inv_set = inv_ea_i[IDX_LSB +: SET_W];

  // Buffer 0 serves instruction fetches, buffer 1 data accesses.
  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic fill_sel;
    assign fill_sel = fill_req_i & (fill_dside_i == (g != 0));

    tlbsync_vld_array #(
      .SET_W (SET_W),
      .WAY_W (WAY_W)
    ) u_arr (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .inv_en_i   (inv_go),
      .inv_set_i  (inv_set),
      .fill_en_i  (fill_sel),
      .fill_set_i (fill_set_i),
      .fill_way_i (fill_way_i),
      .vld_o      (vld_w[g]),
      .clr_o      (clr_w[g])
    );
  end

  assign itlb_vld_o = vld_w[0];
  assign dtlb_vld_o = vld_w[1];
  assign itlb_clr_o = clr_w[0];
  assign dtlb_clr_o = clr_w[1];

  AST_PAIR_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (itlb_clr_o == dtlb_clr_o)); // R2
  AST_STALL_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall_o |=> (itlb_clr_o == '0)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (!stall_o && !illegal_o && (itlb_vld_o == '0) && (dtlb_vld_o == '0))); // R1
endmodule

// File: tb/tb_tlbsync_ctrl.sv
module tb_tlbsync_ctrl;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        inv_req_i, inva_req_i, sync_req_i, sync_hold_i;
  logic [31:0] inv_ea_i, snoop_ea_i;
  logic        snoop_inv_i, fill_req_i, fill_dside_i;
  logic [4:0]  fill_set_i;
  logic [0:0]  fill_way_i;
  logic [63:0] itlb_vld_o, dtlb_vld_o, itlb_clr_o, dtlb_clr_o;
  logic        stall_o, illegal_o;

  tlbsync_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .inv_req_i(inv_req_i), .inv_ea_i(inv_ea_i),
    .inva_req_i(inva_req_i), .sync_req_i(sync_req_i), .sync_hold_i(sync_hold_i),
    .snoop_inv_i(snoop_inv_i), .snoop_ea_i(snoop_ea_i),
    .fill_req_i(fill_req_i), .fill_dside_i(fill_dside_i),
    .fill_set_i(fill_set_i), .fill_way_i(fill_way_i),
    .itlb_vld_o(itlb_vld_o), .dtlb_vld_o(dtlb_vld_o),
    .itlb_clr_o(itlb_clr_o), .dtlb_clr_o(dtlb_clr_o),
    .stall_o(stall_o), .illegal_o(illegal_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [63:0] m_i, m_d;

  // Entries of set s are s*2 and s*2+1 (R2)
  function automatic logic [63:0] set_mask(input logic [4:0] s);
    logic [63:0] m;
    m = '0;
    m[{s, 1'b0}] = 1'b1;
    m[{s, 1'b1}] = 1'b1;
    return m;
  endfunction

  // Index lives in ea[16:12], everything else is noise (R3)
  function automatic logic [31:0] ea_for(input logic [4:0] s, input logic [31:0] noise);
    return (noise & ~32'h0001_F000) | ({27'd0, s} << 12);
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic idle_in();
    inv_req_i = 0; inva_req_i = 0; sync_req_i = 0; snoop_inv_i = 0; fill_req_i = 0;
    inv_ea_i = '0; snoop_ea_i = '0; fill_dside_i = 0; fill_set_i = '0; fill_way_i = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string tag, input logic [63:0] eclr, input logic eill, input logic estall);
    chk(tag, "itlb valid", itlb_vld_o, m_i);
    chk(tag, "dtlb valid", dtlb_vld_o, m_d);
    chk(tag, "itlb clear", itlb_clr_o, eclr);
    chk(tag, "dtlb clear", dtlb_clr_o, eclr);
    chk(tag, "illegal", {63'd0, illegal_o}, {63'd0, eill});
    chk(tag, "stall", {63'd0, stall_o}, {63'd0, estall});
  endtask

  task automatic do_fill(input logic dside, input logic [4:0] s, input logic w);
    fill_req_i = 1; fill_dside_i = dside; fill_set_i = s; fill_way_i = w;
    tick();
    idle_in();
    if (dside) m_d[{s, w}] = 1'b1; else m_i[{s, w}] = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7321);
    idle_in();
    sync_hold_i = 0;
    rst_n = 0;
    m_i = '0; m_d = '0;
    @(negedge clk);
    check_all("R1", '0, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) tick();
    check_all("R1", '0, 0, 0);

    // populate everything, then sweep the index (R10, R3)
    for (int s = 0; s < 32; s++) begin
      for (int w = 0; w < 2; w++) begin
        do_fill(1'b0, 5'(s), 1'(w));
        do_fill(1'b1, 5'(s), 1'(w));
      end
    end
    check_all("R10", '0, 0, 0);
    for (int s = 0; s < 32; s++) begin
      inv_req_i = 1; inv_ea_i = ea_for(5'(s), $urandom);
      tick();
      idle_in();
      m_i &= ~set_mask(5'(s));
      m_d &= ~set_mask(5'(s));
      check_all("R3", set_mask(5'(s)), 0, 0);
    end
    chk("R3", "itlb all clear", itlb_vld_o, '0);
    chk("R3", "dtlb all clear", dtlb_vld_o, '0);

    // random mix
    for (int k = 0; k < 600; k++) begin
      int unsigned op;
      logic [4:0]  s;
      logic [63:0] eclr;
      logic        eill;
      string       tag;
      op = $urandom % 8;
      s = 5'($urandom);
      eclr = '0; eill = 0; tag = "R2";
      case (op)
        0, 1: begin
          inv_req_i = 1; inv_ea_i = ea_for(s, $urandom);
          m_i &= ~set_mask(s); m_d &= ~set_mask(s); eclr = set_mask(s);
        end
        2, 3: begin
          tag = "R10";
          fill_req_i = 1; fill_dside_i = 1'($urandom); fill_set_i = 5'($urandom); fill_way_i = 1'($urandom);
          if (fill_dside_i) m_d[{fill_set_i, fill_way_i}] = 1'b1;
          else m_i[{fill_set_i, fill_way_i}] = 1'b1;
        end
        4: begin
          tag = "R5";
          snoop_inv_i = 1; snoop_ea_i = $urandom;
        end
        5: begin
          tag = "R4"; inva_req_i = 1; eill = 1;
        end
        6: begin
          tag = "R8"; sync_req_i = 1;
        end
        default: begin
          tag = "R10";
          inv_req_i = 1; inv_ea_i = ea_for(s, $urandom);
          fill_req_i = 1; fill_dside_i = 1'($urandom); fill_set_i = s; fill_way_i = 1'($urandom);
          m_i &= ~set_mask(s); m_d &= ~set_mask(s); eclr = set_mask(s);
        end
      endcase
      tick();
      idle_in();
      check_all(tag, eclr, eill, 0);
    end

    // directed stall sequence (R6, R9, R7)
    do_fill(1'b0, 5'd5, 1'b0);
    do_fill(1'b1, 5'd5, 1'b1);
    sync_hold_i = 1;
    repeat (3) tick();
    sync_req_i = 1;
    tick();
    idle_in();
    check_all("R6", '0, 0, 1);
    repeat (2) begin
      tick();
      check_all("R6", '0, 0, 1);
    end
    inv_req_i = 1; inv_ea_i = ea_for(5'd5, 32'hFFFF_FFFF);
    inva_req_i = 1; sync_req_i = 1;
    tick();
    idle_in();
    check_all("R9", '0, 0, 1);
    sync_hold_i = 0;
    tick();
    check_all("R7", '0, 0, 1);
    tick();
    check_all("R7", '0, 0, 1);
    tick();
    check_all("R7", '0, 0, 0);

    // quiet synchronize (R8)
    sync_req_i = 1;
    tick();
    idle_in();
    check_all("R8", '0, 0, 0);
    tick();
    check_all("R8", '0, 0, 0);

    // reset in the middle of a stall (R1)
    sync_hold_i = 1;
    repeat (3) tick();
    sync_req_i = 1;
    tick();
    idle_in();
    check_all("R6", '0, 0, 1);
    rst_n = 0;
    #1;
    m_i = '0; m_d = '0;
    check_all("R1", '0, 0, 0);
    sync_hold_i = 0;
    tick();
    rst_n = 1;
    repeat (3) tick();
    check_all("R1", '0, 0, 0);

    summary();
    done = 1'b1;
    $finish;
  end
endmodule